// File: doc/BRIEF.md
# Internal Clock Postscaler Selector

This block takes a fast internal oscillator clock (nominally 8 MHz) and an independent slow low-power RC clock (nominally 31 kHz) and produces one postscaled clock whose rate is picked by a 3-bit frequency code. One free-running 8-bit counter on the fast clock supplies every divided rate as a power-of-two tap. A source bit decides what the lowest code means. With the bit set, the lowest code gives the fast clock divided by 256 (31.25 kHz). With the bit clear, it gives the slow RC clock. The raw RC clock also leaves the block on a dedicated output for the watchdog and the clock monitor. That output never depends on the source bit.

Both fields sit in a small configuration register that loads on a rising fast edge when `cfg_we` is high. Any reset returns the register to the 4 MHz code, with the source bit clear. A rate change needs no handshake. A two-state switch controller, clocked on the falling fast edge, moves the output mux to the new tap at the first falling edge where both the old tap and the new tap are low. The output therefore never shows a shortened pulse.

The switch controller has two states. `SW_RUN` means the mux follows the requested tap. `SW_PEND` means a change has been requested but has not yet been applied. The transitions are as follows:
- RUN to PEND (defer): the request differs from the active tap and one of the two taps is high.
- RUN to RUN with a switch (direct): the request differs from the active tap and both taps are low.
- PEND to RUN with a switch (apply): both taps are low.
- PEND to RUN without a switch (cancel): the request returns to the active tap.

Top module: `clkpost`

## Requirements
- R1: After reset the frequency code is 110 (4 MHz), the source bit is 0 and the divider counter is zero. As a result, `clk_out` rises at the first rising `clk_fast` edge after reset is released, then toggles at every rising edge (period 2 fast cycles).
- R2: With code 111, `clk_out` equals `clk_fast`: high while `clk_fast` is high and low while it is low.
- R3: With a code c from 001 to 110, `clk_out` has a period of 2^(7-c) fast cycles and is high for half of it (110 gives 2, 001 gives 64).
- R4: With code 000 and the source bit at 1, `clk_out` has a period of 256 fast cycles and is high for 128 of them. For any nonzero code, the source bit has no effect on `clk_out`.
- R5: With code 000 and the source bit at 0, `clk_out` follows `clk_slow` through a two-stage synchronizer on `clk_fast`. Its period and high time match those of `clk_slow` to within one fast cycle.
- R6: `clk_wdt` equals `clk_slow` at all times, whatever the code and the source bit hold.
- R7: The active tap changes only on a falling `clk_fast` edge at which both the old tap and the new tap are low. Outside reset, `clk_out` never has a high or low pulse shorter than half a fast period.
- R8: A write loads `cfg_freq` and `cfg_src` together on a rising edge with `cfg_we` high. The new tap is applied at the first falling edge where both taps are low. Between two codes that both derive from the counter, the change is therefore complete within the longer of the two periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast internal oscillator clock (nominally 8 MHz) |
| clk_slow | input | 1 | Slow low-power RC clock (nominally 31 kHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe, sampled on the rising `clk_fast` edge |
| cfg_freq | input | 3 | Frequency code to load |
| cfg_src | input | 1 | Lowest-code source to load: 1 for divide-by-256, 0 for the RC clock |
| clk_out | output | 1 | Postscaled internal clock |
| clk_wdt | output | 1 | RC clock for the watchdog and the clock monitor |

## Verification
The hardest case to reach from the ports is a rate change issued while the old tap is high. In that case the controller has to sit in the pending state and then apply the switch later, on a shared low phase. The worst form of this is a move between the asynchronous RC tap and a counter tap. The stimulus reaches these cases with seeded random sequences of codes and source bits, so that writes land at arbitrary phases of both clocks. An edge monitor times every high and low pulse of `clk_out` across all of these changes, which catches any runt pulse. Directed steps add the rest: a sweep of all codes, toggling the source bit under a nonzero code, and a reset issued in the middle of a run.

// File: rtl/clkpost_pkg.sv
`timescale 1ns/1ps
package clkpost_pkg;

    // States of the tap switch controller
    typedef enum logic [0:0] {
        SW_RUN  = 1'b0,
        SW_PEND = 1'b1
    } sw_state_e;

endpackage

// File: rtl/clkpost_divider.sv
`timescale 1ns/1ps
module clkpost_divider #(
    parameter int DIV_W    = 8,
    parameter int TOP_CODE = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [TOP_CODE-1:0] taps_o
);

    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // Tap 0 is the deepest stage; tap t (t >= 1) divides by 2^(TOP_CODE - t)
    for (genvar t = 0; t < TOP_CODE; t++) begin : g_map
        if (t == 0) begin : g_deep
            assign taps_o[t] = cnt[DIV_W-1];
        end else begin : g_mid
            assign taps_o[t] = cnt[TOP_CODE-1-t];
        end
    end

    // R4
    deep_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(taps_o[0]) |-> ($past(cnt[DIV_W-2:0]) == {(DIV_W-1){1'b1}}));

endmodule

// File: rtl/clkpost_sync.sv
`timescale 1ns/1ps
module clkpost_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe[STAGES-1];

    // R5
    sync_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_o != $past(q_o)) |-> (q_o == $past(pipe[STAGES-2])));

endmodule

// File: rtl/clkpost_tapsel.sv
`timescale 1ns/1ps
module clkpost_tapsel
    import clkpost_pkg::*;
#(
    parameter int FSEL_W     = 3,
    parameter int RESET_CODE = 6
) (
    input  logic                     clk_fast,
    input  logic                     rst_n,
    input  logic [(1<<FSEL_W)-2:0]   taps_i,
    input  logic                     slow_i,
    input  logic [FSEL_W-1:0]        freq_i,
    input  logic                     src_i,
    output logic                     clk_o
);

    localparam int TOP_CODE = (1 << FSEL_W) - 1;
    localparam int SLOW_IDX = TOP_CODE + 1;
    localparam int IDX_W    = $clog2(SLOW_IDX + 1);
    localparam int NTAP     = 1 << IDX_W;

    // Tap levels as seen on a falling fast edge; the undivided tap is low there
    logic [NTAP-1:0] tap_lvl;

    for (genvar t = 0; t < NTAP; t++) begin : g_tap
        if (t < TOP_CODE) begin : g_div
            assign tap_lvl[t] = taps_i[t];
        end else if (t == SLOW_IDX) begin : g_slow
            assign tap_lvl[t] = slow_i;
        end else begin : g_zero
            assign tap_lvl[t] = 1'b0;
        end
    end

    logic [IDX_W-1:0] req_idx;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] cur_nx;
    logic             both_low;
    sw_state_e        state;
    sw_state_e        state_nx;

    always_comb begin
        if (freq_i == '0) begin
            req_idx = src_i ? IDX_W'(0) : IDX_W'(SLOW_IDX);
        end else begin
            req_idx = IDX_W'(freq_i);
        end
    end

    assign both_low = !tap_lvl[cur_idx] && !tap_lvl[req_idx];

    // State register: falling edge, when every tap is steady
    always_ff @(negedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            state   <= SW_RUN;
            cur_idx <= IDX_W'(RESET_CODE);
        end else begin
            state   <= state_nx;
            cur_idx <= cur_nx;
        end
    end

    // Next state and tap choice
    always_comb begin
        state_nx = state;
        cur_nx   = cur_idx;
        unique case (state)
            SW_RUN: begin
                if (req_idx != cur_idx) begin
                    if (both_low) begin
                        cur_nx = req_idx;
                    end else begin
                        state_nx = SW_PEND;
                    end
                end
            end
            SW_PEND: begin
                if (req_idx == cur_idx) begin
                    state_nx = SW_RUN;
                end else if (both_low) begin
                    cur_nx   = req_idx;
                    state_nx = SW_RUN;
                end
            end
            default: state_nx = SW_RUN;
        endcase
    end

    // Output mux
    always_comb begin
        if (cur_idx == IDX_W'(TOP_CODE)) begin
            clk_o = clk_fast;
        end else begin
            clk_o = tap_lvl[cur_idx];
        end
    end

    // R7
    sw_on_low_chk: assert property (@(negedge clk_fast) disable iff (!rst_n)
        (cur_idx != $past(cur_idx)) |-> $past(both_low));

    // R8
    first_chance_chk: assert property (@(negedge clk_fast) disable iff (!rst_n)
        ($past(both_low) && ($past(req_idx) != $past(cur_idx)))
        |-> (cur_idx == $past(req_idx)));

    // R3
    idx_range_chk: assert property (@(negedge clk_fast) disable iff (!rst_n)
        cur_idx <= IDX_W'(SLOW_IDX));

    // R8
    pend_hold_chk: assert property (@(negedge clk_fast) disable iff (!rst_n)
        (state == SW_PEND) |-> (cur_idx == $past(cur_idx)));

endmodule

// File: rtl/clkpost.sv
`timescale 1ns/1ps
module clkpost #(
    parameter int FSEL_W      = 3,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RESET_CODE  = 6
) (
    input  logic              clk_fast,
    input  logic              clk_slow,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [FSEL_W-1:0] cfg_freq,
    input  logic              cfg_src,
    output logic              clk_out,
    output logic              clk_wdt
);

    localparam int TOP_CODE = (1 << FSEL_W) - 1;

    logic [FSEL_W-1:0]   freq_q;
    logic                src_q;
    logic [TOP_CODE-1:0] taps;
    logic                slow_s;

    // Configuration register
    always_ff @(posedge clk_fast or negedge rst_n) begin
        if (!rst_n) begin
            freq_q <= FSEL_W'(RESET_CODE);
            src_q  <= 1'b0;
        end else if (cfg_we) begin
            freq_q <= cfg_freq;
            src_q  <= cfg_src;
        end
    end

    clkpost_divider #(
        .DIV_W    (DIV_W),
        .TOP_CODE (TOP_CODE)
    ) u_div (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .taps_o (taps)
    );

    clkpost_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk_fast),
        .rst_n (rst_n),
        .d_i   (clk_slow),
        .q_o   (slow_s)
    );

    clkpost_tapsel #(
        .FSEL_W     (FSEL_W),
        .RESET_CODE (RESET_CODE)
    ) u_sel (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .taps_i   (taps),
        .slow_i   (slow_s),
        .freq_i   (freq_q),
        .src_i    (src_q),
        .clk_o    (clk_out)
    );

    // Watchdog and monitor clock is the RC clock
    assign clk_wdt = clk_slow;

    // R1
    rst_default_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(rst_n) |-> ((freq_q == FSEL_W'(RESET_CODE)) && !src_q));

endmodule

// File: tb/clkpost_tb.sv
`timescale 1ns/1ps
module clkpost_tb;

    localparam int SLOW_HALF = 1930;   // ns, slow period = 386 fast cycles
    localparam int SLOW_PER  = 386;

    logic       clk_fast = 1'b0;
    logic       clk_slow = 1'b0;
    logic       rst_n    = 1'b0;
    logic       cfg_we   = 1'b0;
    logic [2:0] cfg_freq = 3'd0;
    logic       cfg_src  = 1'b0;
    logic       clk_out;
    logic       clk_wdt;

    int n_checks = 0;
    int n_fails  = 0;
    int runts    = 0;
    int pulses   = 0;

    clkpost u_dut (
        .clk_fast (clk_fast),
        .clk_slow (clk_slow),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_freq (cfg_freq),
        .cfg_src  (cfg_src),
        .clk_out  (clk_out),
        .clk_wdt  (clk_wdt)
    );

    always #5 clk_fast = ~clk_fast;

    initial begin
        #3;
        forever #(SLOW_HALF) clk_slow = ~clk_slow;
    end

    // Pulse-width monitor on clk_out (R7)
    realtime t_last = 0.0;
    bit      t_valid = 1'b0;
    logic    last_out = 1'b0;
    always @(clk_out or rst_n) begin
        if (!rst_n) begin
            t_valid  = 1'b0;
            last_out = clk_out;
        end else if (clk_out !== last_out) begin
            if (t_valid) begin
                pulses++;
                if ($realtime - t_last < 4.9) runts++;
            end
            t_last   = $realtime;
            t_valid  = 1'b1;
            last_out = clk_out;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_period(input int code, input bit src);
        if (code == 7) return 1;
        if (code == 0) return src ? 256 : SLOW_PER;
        return 1 << (7 - code);
    endfunction

    task automatic write_cfg(input int code, input bit src);
        @(negedge clk_fast);
        cfg_we   = 1'b1;
        cfg_freq = 3'(code);
        cfg_src  = src;
        @(negedge clk_fast);
        cfg_we   = 1'b0;
    endtask

    task automatic measure(output int per, output int hi, output bit ok);
        int  r1 = -1;
        int  r2 = -1;
        int  f1 = -1;
        bit  prev;
        @(posedge clk_fast); #1;
        prev = clk_out;
        for (int i = 1; i < 1000 && r2 < 0; i++) begin
            @(posedge clk_fast); #1;
            if (!prev && clk_out) begin
                if (r1 < 0) r1 = i;
                else r2 = i;
            end
            if (prev && !clk_out && r1 >= 0 && f1 < 0) f1 = i;
            prev = clk_out;
        end
        ok  = (r2 >= 0) && (f1 >= 0);
        per = r2 - r1;
        hi  = f1 - r1;
    endtask

    task automatic check_cfg(input int code, input bit src, input string req);
        int per;
        int hi;
        bit ok;
        int ep;
        int tol;
        if (code == 7) begin
            int bad = 0;
            for (int k = 0; k < 8; k++) begin
                @(posedge clk_fast); #1;
                if (clk_out !== 1'b1) bad++;
                @(negedge clk_fast); #1;
                if (clk_out !== 1'b0) bad++;
            end
            check(bad == 0, req, "undivided tap mismatches", bad, 0);
        end else begin
            ep  = exp_period(code, src);
            tol = (code == 0 && !src) ? 1 : 0;
            measure(per, hi, ok);
            check(ok, req, "two rising edges seen", int'(ok), 1);
            check((per >= ep - tol) && (per <= ep + tol), req, "period", per, ep);
            check((hi >= ep / 2 - tol) && (hi <= ep / 2 + tol), req, "high time", hi, ep / 2);
        end
        // R6
        #2;
        check(clk_wdt === clk_slow, "R6", "clk_wdt vs clk_slow", int'(clk_wdt), int'(clk_slow));
    endtask

    task automatic apply(input int code, input bit src, input int old_code,
                         input bit old_src, input string req);
        int pn = exp_period(code, src);
        int po = exp_period(old_code, old_src);
        int wait_c;
        write_cfg(code, src);
        if ((code == 0 && !src) || (old_code == 0 && !old_src)) wait_c = 800;
        else wait_c = ((pn > po) ? pn : po) + 4;   // R8 latency bound
        repeat (wait_c) @(posedge clk_fast);
        check_cfg(code, src, req);
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        cfg_we = 1'b0;
        repeat (3) @(posedge clk_fast);
        #2 rst_n = 1'b1;
        // R1: divider starts at zero, default 4 MHz tap rises at first edge
        @(posedge clk_fast); #1;
        check(clk_out === 1'b1, "R1", "clk_out after first edge", int'(clk_out), 1);
        @(posedge clk_fast); #1;
        check(clk_out === 1'b0, "R1", "clk_out after second edge", int'(clk_out), 0);
        check_cfg(6, 1'b0, "R1");
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk_fast);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin : main
        int oc;
        bit os;
        int nc;
        bit ns;
        int unsigned seed_init;
        seed_init = $urandom(32'd20240611);

        do_reset();
        oc = 6;
        os = 1'b0;

        // Directed sweep: R2, R3, R4, R5
        apply(7, 1'b1, oc, os, "R2");
        apply(5, 1'b1, 7, 1'b1, "R3");
        apply(1, 1'b1, 5, 1'b1, "R3");
        apply(0, 1'b1, 1, 1'b1, "R4");
        apply(0, 1'b0, 0, 1'b1, "R5");
        apply(3, 1'b0, 0, 1'b0, "R3");
        // R4: source bit ignored for a nonzero code
        apply(3, 1'b1, 3, 1'b0, "R4");
        apply(7, 1'b0, 3, 1'b1, "R2");
        apply(0, 1'b0, 7, 1'b0, "R5");
        oc = 0;
        os = 1'b0;

        // Random configuration sequence: R8 plus per-code checks
        for (int n = 0; n < 20; n++) begin
            nc = int'($urandom % 8);
            ns = 1'(($urandom >> 4) & 1);
            apply(nc, ns, oc, os, "R8");
            oc = nc;
            os = ns;
        end

        // Reset in the middle of a run: R1
        write_cfg(1, 1'b1);
        repeat (37) @(posedge clk_fast);
        do_reset();

        // R7: no runt pulses across all switches
        check(runts == 0, "R7", "runt pulses", runts, 0);
        check(pulses > 100, "R7", "pulses observed", pulses, 101);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule